// File: doc/BRIEF.md
# Staged Translation Buffer with Two-Step Fill

This block holds two small, fully associative address translation buffers: one for data accesses and one for instruction fetches. Software fills them through an indexed register write port, and each fill takes two writes. On the data side the page-table entry is written first and held in a staging register. A later tag write, carrying the virtual address, commits the entry, and the entry takes the data address-space number (ASN) that is current at that moment. The instruction side uses the opposite order. The tag is staged first, and the page-table entry write commits the entry with its write-enable mask cleared. If the entry being committed has a nonzero granularity-hint field, the block raises an error and inserts nothing.

Control writes remove entries in three ways: all entries, only the non-global entries, or the entries that match one address under the current ASN. A combinational lookup port takes a side select, a virtual page number and an ASN, and returns a hit flag and the physical page number. A readback port repacks any stored entry into page-table-entry layout. A new entry overwrites an existing entry with the same page and ASN. Otherwise it goes into the slot named by a round-robin pointer. Page-table walking is not part of this block.

Top module: `xlat_staged_tb`

## Requirements
- R1: After reset every entry on both sides is invalid, so every lookup misses and every readback shows valid low. The error output is low.
- R2: A data-side write to the page-table-entry code (wr_sel 0) only stages the entry. Lookups keep missing until a tag write.
- R3: A data-side tag write (wr_sel 1) inserts the staged page-table entry under the virtual page in wr_data[PAGE_SHIFT +: VPN_W]. The entry takes the data ASN, which an ASN write (wr_sel 2) loads from wr_data[63:57]. The entry is visible to lookups from the cycle after the write.
- R4: On the instruction side, a tag write (wr_sel 9) only stages the page. A page-table-entry write (wr_sel 8) commits the entry with the write-enable mask at bits [15:12] forced to zero. The entry takes the instruction ASN, which wr_sel 10 loads from wr_data[10:4].
- R5: A lookup hits when a valid entry has the same virtual page and either the same ASN or the global bit set. lk_side 0 selects the data buffer and lk_side 1 selects the instruction buffer.
- R6: A commit whose page-table entry has a nonzero granularity hint in bits [6:5] inserts nothing and leaves the round-robin pointer unchanged. err is high for exactly the one cycle after that write.
- R7: The invalidate-all code (wr_sel 3 on the data side, 11 on the instruction side) clears every entry of that side.
- R8: The invalidate-process code (wr_sel 4 or 12) clears only the entries whose global bit is clear.
- R9: The single-address code (wr_sel 5 or 13) removes the entries whose page equals the page in wr_data and that match the side's current ASN or are global.
- R10: rb_pte repacks entry rb_idx of side rb_side as follows:
  - physical page at [58:32]
  - read-enable mask at [11:8]
  - write-enable mask at [15:12]
  - fault-on-read at bit 1
  - fault-on-write at bit 2
  - global at bit 4
  - ASN at [63:57]
  - every other bit zero
- R11: An insert whose page and ASN match a valid entry overwrites that entry and does not move the pointer. Any other insert goes into the pointer's slot, and the pointer then advances, wrapping after ENTRIES-1.
- R12: Writes to one side never change the other side's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register code; bit 3 selects the instruction side |
| wr_data | input | 64 | Write data |
| lk_side | input | 1 | Lookup side: 0 data, 1 instruction |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | 7 | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Physical page number of the hit |
| rb_side | input | 1 | Readback side |
| rb_idx | input | log2(ENTRIES) | Readback entry index |
| rb_valid | output | 1 | Readback entry is valid |
| rb_pte | output | 64 | Readback entry in page-table-entry layout |
| err | output | 1 | One-cycle pulse after a rejected commit |

## Verification
The bench checks the points where the two fill orders differ. If the staging behaviour were swapped, a lookup would hit after the first write of a pair, or the instruction entry would keep its write-enable mask. A rejected commit with a bad granularity hint is followed by a lookup and by later slot placement. A design that inserted anyway, or moved the pointer, would show a stray hit or a shifted slot. The process invalidate runs against a mix of global and private entries, so clearing the wrong set is visible. Same-key overwrite and pointer wrap are checked through readback of specific slots, where an off-by-one pointer or a duplicate entry shows up directly.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PPN_W  = 27;
  localparam int ASN_W  = 7;
  localparam int MASK_W = 4;

  typedef enum logic [2:0] {
    OP_PTE      = 3'd0,
    OP_TAG      = 3'd1,
    OP_ASN      = 3'd2,
    OP_INV_ALL  = 3'd3,
    OP_INV_PROC = 3'd4,
    OP_INV_ONE  = 3'd5
  } xlat_op_e;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [MASK_W-1:0] rd_mask;
    logic [MASK_W-1:0] wr_mask;
    logic              flt_rd;
    logic              flt_wr;
    logic              glb;
    logic [ASN_W-1:0]  asn;
  } xlat_ent_t;

  function automatic logic hint_bad(input logic [63:0] d);
    return |d[6:5];
  endfunction

  function automatic xlat_ent_t unpack_pte(input logic [63:0] d,
                                           input logic [ASN_W-1:0] asn,
                                           input logic kill_wr);
    xlat_ent_t e;
    e.ppn     = d[58:32];
    e.rd_mask = d[11:8];
    e.wr_mask = kill_wr ? '0 : d[15:12];
    e.flt_rd  = d[1];
    e.flt_wr  = d[2];
    e.glb     = d[4];
    e.asn     = asn;
    return e;
  endfunction

  function automatic logic [63:0] pack_pte(input xlat_ent_t e);
    logic [63:0] d;
    d        = '0;
    d[58:32] = e.ppn;
    d[11:8]  = e.rd_mask;
    d[15:12] = e.wr_mask;
    d[1]     = e.flt_rd;
    d[2]     = e.flt_wr;
    d[4]     = e.glb;
    d[63:57] = e.asn;
    return d;
  endfunction

  function automatic logic [ASN_W-1:0] asn_field(input logic [63:0] d, input logic instr);
    return instr ? d[10:4] : d[63:57];
  endfunction
endpackage

// File: rtl/xlat_stage.sv
module xlat_stage
  import xlat_pkg::*;
#(
  parameter bit IS_INSTR   = 1'b0,
  parameter int VPN_W      = 30,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_op,
  input  logic [63:0]       wr_data,
  output logic [ASN_W-1:0]  cur_asn,
  output logic              ins_fire,
  output logic [VPN_W-1:0]  ins_vpn,
  output xlat_ent_t         ins_ent,
  output logic              gh_err,
  output logic              inv_all,
  output logic              inv_proc,
  output logic              inv_one,
  output logic [VPN_W-1:0]  inv_vpn
);
  logic [VPN_W-1:0] page_in;
  logic             commit;
  logic [63:0]      pte_src;
  logic [VPN_W-1:0] vpn_src;
  logic [ASN_W-1:0] asn_q;

  assign page_in = wr_data[PAGE_SHIFT +: VPN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         asn_q <= '0;
    else if (wr_en && wr_op == OP_ASN)  asn_q <= asn_field(wr_data, IS_INSTR);
  end
  assign cur_asn = asn_q;

  generate
    if (IS_INSTR) begin : g_instr
      logic [VPN_W-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         tag_q <= '0;
        else if (wr_en && wr_op == OP_TAG)  tag_q <= page_in;
      end
      assign commit  = wr_en && wr_op == OP_PTE;
      assign pte_src = wr_data;
      assign vpn_src = tag_q;
    end else begin : g_data
      logic [63:0] pte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pte_q <= '0;
        else if (wr_en && wr_op == OP_PTE)  pte_q <= wr_data;
      end
      assign commit  = wr_en && wr_op == OP_TAG;
      assign pte_src = pte_q;
      assign vpn_src = page_in;
    end
  endgenerate

  assign gh_err   = commit && hint_bad(pte_src);
  assign ins_fire = commit && !hint_bad(pte_src);
  assign ins_vpn  = vpn_src;
  assign ins_ent  = unpack_pte(pte_src, asn_q, IS_INSTR);
  assign inv_all  = wr_en && wr_op == OP_INV_ALL;
  assign inv_proc = wr_en && wr_op == OP_INV_PROC;
  assign inv_one  = wr_en && wr_op == OP_INV_ONE;
  assign inv_vpn  = page_in;
endmodule

// File: rtl/xlat_bank.sv
module xlat_bank
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_fire,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  xlat_ent_t         ins_ent,
  input  logic              inv_all,
  input  logic              inv_proc,
  input  logic              inv_one,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASN_W-1:0]  cur_asn,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output xlat_ent_t         rb_ent,
  output logic [IDX_W-1:0]  ptr,
  output logic              repl_hit
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  xlat_ent_t          ent_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] hit_vec, same_vec, kill_vec;
  logic [IDX_W-1:0]   repl_idx, tgt_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i]  = vld_q[i] && vpn_q[i] == lk_vpn &&
                         (ent_q[i].asn == lk_asn || ent_q[i].glb);
    assign same_vec[i] = vld_q[i] && vpn_q[i] == ins_vpn && ent_q[i].asn == ins_ent.asn;
    assign kill_vec[i] = inv_all ||
                         (inv_proc && !ent_q[i].glb) ||
                         (inv_one && vpn_q[i] == inv_vpn &&
                          (ent_q[i].asn == cur_asn || ent_q[i].glb));
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !lk_hit) begin
        lk_hit = 1'b1;
        lk_ppn = ent_q[i].ppn;
      end
    end
  end

  always_comb begin
    repl_hit = 1'b0;
    repl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_vec[i]) begin
        repl_hit = 1'b1;
        repl_idx = IDX_W'(i);
      end
    end
  end

  assign tgt_idx = repl_hit ? repl_idx : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ent_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_q & ~kill_vec;
      if (ins_fire) begin
        vld_q[tgt_idx] <= 1'b1;
        vpn_q[tgt_idx] <= ins_vpn;
        ent_q[tgt_idx] <= ins_ent;
        if (!repl_hit)
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign rb_valid = vld_q[rb_idx];
  assign rb_ent   = ent_q[rb_idx];
  assign ptr      = ptr_q;
endmodule

// File: rtl/xlat_staged_tb.sv
module xlat_staged_tb
  import xlat_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int VPN_W      = 30,
  parameter int PAGE_SHIFT = 13,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [63:0]       wr_data,
  input  logic              lk_side,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              rb_side,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [63:0]       rb_pte,
  output logic              err
);
  logic [1:0]             side_ins, side_gh, side_repl, side_hit, side_rbv;
  logic [1:0][IDX_W-1:0]  side_ptr;
  logic [1:0][PPN_W-1:0]  side_ppn;
  xlat_ent_t              side_rbe [2];
  logic                   err_q;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [ASN_W-1:0] cur_asn;
    logic [VPN_W-1:0] ins_vpn, inv_vpn;
    xlat_ent_t        ins_ent;
    logic             inv_all, inv_proc, inv_one;

    xlat_stage #(.IS_INSTR(s == 1), .VPN_W(VPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && wr_sel[3] == 1'(s)), .wr_op(wr_sel[2:0]), .wr_data(wr_data),
      .cur_asn(cur_asn), .ins_fire(side_ins[s]), .ins_vpn(ins_vpn), .ins_ent(ins_ent),
      .gh_err(side_gh[s]), .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
      .inv_vpn(inv_vpn)
    );

    xlat_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ins_fire(side_ins[s]), .ins_vpn(ins_vpn), .ins_ent(ins_ent),
      .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one), .inv_vpn(inv_vpn),
      .cur_asn(cur_asn), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
      .lk_hit(side_hit[s]), .lk_ppn(side_ppn[s]),
      .rb_idx(rb_idx), .rb_valid(side_rbv[s]), .rb_ent(side_rbe[s]),
      .ptr(side_ptr[s]), .repl_hit(side_repl[s])
    );
  end

  assign lk_hit   = side_hit[lk_side];
  assign lk_ppn   = side_ppn[lk_side];
  assign rb_valid = side_rbv[rb_side];
  assign rb_pte   = pack_pte(side_rbe[rb_side]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |side_gh;
  end
  assign err = err_q;
endmodule

// File: rtl/xlat_staged_chk.sv
module xlat_staged_chk #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [3:0]            wr_sel,
  input logic                  lk_side,
  input logic                  lk_hit,
  input logic                  rb_side,
  input logic                  rb_valid,
  input logic [63:0]           rb_pte,
  input logic                  err,
  input logic [1:0]            side_ins,
  input logic [1:0]            side_gh,
  input logic [1:0]            side_repl,
  input logic [1:0][IDX_W-1:0] side_ptr
);
  assert_err_follows_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|side_gh) |=> err);

  assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(|side_gh));

  assert_inv_all_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'h3) |=> !(lk_side == 1'b0 && lk_hit));

  assert_instr_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_side && rb_valid) |-> rb_pte[15:12] == 4'h0);

  for (genvar s = 0; s < 2; s++) begin : g_chk
    assert_bad_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      side_gh[s] |=> side_ptr[s] == $past(side_ptr[s]));

    assert_rr_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (side_ins[s] && !side_repl[s]) |=>
        side_ptr[s] == (($past(side_ptr[s]) == IDX_W'(ENTRIES - 1)) ? '0 : $past(side_ptr[s]) + 1'b1));

    assert_overwrite_holds_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (side_ins[s] && side_repl[s]) |=> $stable(side_ptr[s]));
  end
endmodule

bind xlat_staged_tb xlat_staged_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .lk_side(lk_side), .lk_hit(lk_hit), .rb_side(rb_side), .rb_valid(rb_valid),
  .rb_pte(rb_pte), .err(err), .side_ins(side_ins), .side_gh(side_gh),
  .side_repl(side_repl), .side_ptr(side_ptr)
);

// File: tb/sim_xlat_staged_tb.sv
module sim_xlat_staged_tb;
  localparam int VPN_W = 30;
  localparam int SH    = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        lk_side = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [6:0]  lk_asn = '0;
  logic        lk_hit;
  logic [26:0] lk_ppn;
  logic        rb_side = 1'b0;
  logic [2:0]  rb_idx = '0;
  logic        rb_valid;
  logic [63:0] rb_pte;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlat_staged_tb u0 (.*);

  typedef struct {
    bit          is_rb;
    bit          flag;
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic report(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations once the driven inputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (!e.is_rb)
          report(lk_hit === e.flag && (!e.flag || lk_ppn === e.val[26:0]), e.tag,
                 {lk_hit, 36'd0, lk_ppn}, {e.flag, 36'd0, e.val[26:0]});
        else
          report(rb_valid === e.flag && (!e.flag || rb_pte === e.val), e.tag,
                 e.flag ? rb_pte : {63'd0, rb_valid}, e.flag ? e.val : {63'd0, e.flag});
      end
    end
  end

  task automatic wr(input logic [3:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic look(input bit side, input int vpn, input int asn, input bit hit, input int ppn, input string tag);
    exp_t e;
    @(negedge clk);
    lk_side = side; lk_vpn = VPN_W'(vpn); lk_asn = 7'(asn);
    e.is_rb = 1'b0; e.flag = hit; e.val = 64'(ppn); e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic rb(input bit side, input int idx, input bit vld, input logic [63:0] pte, input string tag);
    exp_t e;
    @(negedge clk);
    rb_side = side; rb_idx = 3'(idx);
    e.is_rb = 1'b1; e.flag = vld; e.val = pte; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic chk_err(input bit exp, input string tag);
    @(negedge clk);
    #1 report(err === exp, tag, {63'd0, err}, {63'd0, exp});
  endtask

  // Builds a page-table-entry word independently of the design's packing.
  function automatic logic [63:0] mk_pte(input int ppn, input int re, input int we,
                                         input bit fr, input bit fw, input bit g, input int gh);
    return (64'(ppn) << 32) + (64'(re) << 8) + (64'(we) << 12) + (64'(fr) << 1)
         + (64'(fw) << 2) + (64'(g) << 4) + (64'(gh) << 5);
  endfunction

  function automatic logic [63:0] va(input int vpn);
    return 64'(vpn) << SH;
  endfunction

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    look(0, 5, 0, 0, 0, "R1 data miss after reset");
    look(1, 5, 0, 0, 0, "R1 instr miss after reset");
    rb(0, 0, 0, '0, "R1 readback invalid");
    chk_err(0, "R1 err low");

    // R2 / R3 data fill
    wr(4'd2, 64'd3 << 57);
    wr(4'd0, mk_pte(27'h123, 5, 10, 1, 0, 0, 0));
    look(0, 16, 3, 0, 0, "R2 staged PTE alone gives no hit");
    wr(4'd1, va(16));
    look(0, 16, 3, 1, 27'h123, "R3 tag commit hit");
    look(0, 16, 4, 0, 0, "R5 ASN mismatch misses");
    rb(0, 0, 1, mk_pte(27'h123, 5, 10, 1, 0, 0, 0) | (64'd3 << 57), "R10 data readback packing");

    // R5 global entry
    wr(4'd0, mk_pte(27'h77, 1, 2, 0, 1, 1, 0));
    wr(4'd1, va(32));
    look(0, 32, 9, 1, 27'h77, "R5 global hit on any ASN");

    // R6 rejected commit
    wr(4'd0, mk_pte(27'h99, 0, 0, 0, 0, 0, 1));
    wr(4'd1, va(48));
    chk_err(1, "R6 err after bad hint");
    chk_err(0, "R6 err one cycle only");
    look(0, 48, 3, 0, 0, "R6 no insert on bad hint");

    // R4 instruction fill, R12 side isolation
    wr(4'd10, 64'd5 << 4);
    wr(4'd9, va(64));
    look(1, 64, 5, 0, 0, "R4 staged tag alone gives no hit");
    wr(4'd8, mk_pte(27'h55, 3, 15, 0, 0, 0, 0));
    look(1, 64, 5, 1, 27'h55, "R4 instr commit hit");
    rb(1, 0, 1, mk_pte(27'h55, 3, 0, 0, 0, 0, 0) | (64'd5 << 57), "R4 instr write mask zero");
    look(0, 64, 5, 0, 0, "R12 data side untouched by instr fill");

    // R8 process invalidate
    wr(4'd4, 64'd0);
    look(0, 16, 3, 0, 0, "R8 private entry removed");
    look(0, 32, 9, 1, 27'h77, "R8 global entry kept");

    // R9 single-address invalidate; slot 2 since the rejected commit kept the pointer
    wr(4'd0, mk_pte(27'h321, 0, 0, 0, 0, 0, 0));
    wr(4'd1, va(16));
    rb(0, 2, 1, mk_pte(27'h321, 0, 0, 0, 0, 0, 0) | (64'd3 << 57), "R6 pointer unchanged by reject");
    wr(4'd5, va(16));
    look(0, 16, 3, 0, 0, "R9 addressed entry removed");
    look(0, 32, 3, 1, 27'h77, "R9 other entry kept");

    // R7 invalidate all, R12
    wr(4'd3, 64'd0);
    look(0, 32, 9, 0, 0, "R7 all data entries cleared");
    look(1, 64, 5, 1, 27'h55, "R12 instr side survives data flush");

    // R11 replacement; data pointer now 3
    wr(4'd0, mk_pte(1, 0, 0, 0, 0, 0, 0));
    wr(4'd1, va(80));
    wr(4'd0, mk_pte(2, 0, 0, 0, 0, 0, 0));
    wr(4'd1, va(80));
    look(0, 80, 3, 1, 2, "R11 same key overwritten");
    rb(0, 3, 1, mk_pte(2, 0, 0, 0, 0, 0, 0) | (64'd3 << 57), "R11 overwrite in place");
    rb(0, 4, 0, '0, "R11 no duplicate slot");
    for (int k = 0; k < 8; k++) begin
      wr(4'd0, mk_pte(96 + k, 0, 0, 0, 0, 0, 0));
      wr(4'd1, va(96 + k));
    end
    look(0, 80, 3, 0, 0, "R11 wrap evicts oldest slot");
    look(0, 96, 3, 1, 96, "R11 first of batch present");
    rb(0, 3, 1, mk_pte(103, 0, 0, 0, 0, 0, 0) | (64'd3 << 57), "R11 last insert lands in slot 3");

    // R7 instruction side flush
    wr(4'd11, 64'd0);
    look(1, 64, 5, 0, 0, "R7 instr flush");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule